// File: doc/BRIEF.md
# ATA Transfer Cycle Timing Generator

This block turns a packed 32-bit timing word into the strobe waveform of one ATA bus transfer. Software writes the timing word and can read it back. A host-side request stream then asks for single transfers. Each request names the transfer kind (programmed I/O or multiword DMA), the direction, and the write data. For every accepted request the block runs an active access phase, during which the read or write strobe is high. An inactive recovery phase follows. The block then signals completion and returns any captured read data.

All phase lengths are counted in 15 ns ticks. One field unit is 30 ns, which is two ticks, so the half-tick modifier for DMA cycles can be expressed exactly. Programmed I/O recovery always carries a fixed 120 ns (8-tick) offset, and an extend bit can lengthen it by one more unit. DMA recovery carries a fixed 30 ns offset when the half-tick bit is clear. When the half-tick bit is set, each DMA phase gets one extra tick instead. The tick rate is `TICK_DIV` clocks per tick. The tick prescaler restarts with every cycle, so phase lengths are exact multiples of `TICK_DIV`.

The request port is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` and its fields for as long as it likes. The completion output is a one-clock pulse with no back-pressure, so the consumer must take `rsp_rdata` in that clock.

Top module: `ata_cycle_timer`

## Requirements
- R1: After reset, `req_ready` is 1. Both strobes, `bus_drive_en`, `rsp_done` and `cfg_rdata` are 0.
- R2: `cfg_rdata` returns the last written word with bits 31:22 forced to zero. The field positions are fixed:
  - PIO access: bits 4:0
  - PIO recovery: bits 9:5
  - PIO extend: bit 10
  - DMA access: bits 15:11
  - DMA recovery: bits 20:16
  - half-tick: bit 21
- R3: For a PIO cycle, the strobe is high for 2 x PIO-access ticks. A zero access field gives one tick.
- R4: For a PIO cycle, the recovery phase lasts 2 x PIO-recovery + 8 + 2 x extend ticks.
- R5: For a DMA cycle with half-tick clear, access lasts 2 x DMA-access ticks (one tick if the field is zero). Recovery lasts 2 x DMA-recovery + 2 ticks.
- R6: For a DMA cycle with half-tick set, access lasts 2 x DMA-access + 1 ticks. Recovery lasts 2 x DMA-recovery + 1 ticks.
- R7: On a read, `bus_din` is sampled on the last tick of the access phase and presented on `rsp_rdata` while `rsp_done` is high.
- R8: On a write, only `bus_wr_stb` pulses, and `bus_dout` holds the request data. `bus_drive_en` is high from the start of access to the end of recovery. On a read, `bus_drive_en` stays low and only `bus_rd_stb` pulses. The two strobes are never high together.
- R9: `req_ready` is high only while idle. `rsp_done` is high for exactly one clock when recovery ends, and `req_ready` is high in that same clock.
- R10: The timing word is sampled when a request is accepted. A write to it during a cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the timing word |
| cfg_wr_data | input | 32 | Timing word to write |
| cfg_rdata | output | 32 | Timing word read-back, unused bits zero |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_is_dma | input | 1 | 1 = multiword DMA timing, 0 = programmed I/O timing |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_wdata | input | DATA_W | Data for a write transfer |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data, valid with rsp_done |
| bus_rd_stb | output | 1 | Read strobe, high during a read access phase |
| bus_wr_stb | output | 1 | Write strobe, high during a write access phase |
| bus_drive_en | output | 1 | Enables the data drivers for a write cycle |
| bus_is_dma | output | 1 | Current cycle uses DMA timing |
| bus_dout | output | DATA_W | Data driven during a write cycle |
| bus_din | input | DATA_W | Data from the bus for reads |

## Verification
Some properties are checked by the assertions on every cycle:
- the strobes are mutually exclusive and are low while idle;
- the write strobe only appears with the data drivers on;
- the completion pulse lasts one clock and lands on an idle cycle;
- every access phase is followed by at least one tick of recovery;
- the transfer kind stays stable through a cycle;
- the unused read-back bits stay zero.

The exact phase lengths under each combination of fields and modifier bits need the bench's scenarios to show them. So do the read-data capture point and the deferred effect of a mid-cycle register write. There the measured strobe widths and recovery gaps are compared against values computed from the timing word.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;
  localparam int FIELD_W  = 5;
  localparam int REG_W    = 32;
  localparam int USED_W   = 22;
  localparam int PA_LSB   = 0;
  localparam int PR_LSB   = 5;
  localparam int PE_BIT   = 10;
  localparam int MA_LSB   = 11;
  localparam int MR_LSB   = 16;
  localparam int HT_BIT   = 21;

  typedef struct packed {
    logic [FIELD_W-1:0] pio_acc;
    logic [FIELD_W-1:0] pio_rec;
    logic               pio_ext;
    logic [FIELD_W-1:0] dma_acc;
    logic [FIELD_W-1:0] dma_rec;
    logic               half;
  } tim_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RECOV  = 2'd2
  } seq_state_t;

  function automatic tim_fields_t unpack_word(input logic [USED_W-1:0] w);
    tim_fields_t f;
    f.pio_acc = w[PA_LSB +: FIELD_W];
    f.pio_rec = w[PR_LSB +: FIELD_W];
    f.pio_ext = w[PE_BIT];
    f.dma_acc = w[MA_LSB +: FIELD_W];
    f.dma_rec = w[MR_LSB +: FIELD_W];
    f.half    = w[HT_BIT];
    return f;
  endfunction
endpackage

// File: rtl/ata_tim_cfg.sv
module ata_tim_cfg
  import ata_tim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output tim_fields_t         fields
);
  logic [USED_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data[USED_W-1:0];
  end

  assign rd_data = {{(REG_W-USED_W){1'b0}}, word_q};
  assign fields  = unpack_word(word_q);
endmodule

// File: rtl/ata_tim_calc.sv
module ata_tim_calc
  import ata_tim_pkg::*;
#(
  parameter int CNT_W         = 7,
  parameter int PIO_OFS_TICKS = 8,
  parameter int DMA_OFS_TICKS = 2
) (
  input  tim_fields_t       fields,
  input  logic              is_dma,
  output logic [CNT_W-1:0]  acc_ticks,
  output logic [CNT_W-1:0]  rec_ticks
);
  logic [CNT_W-1:0] pio_acc_t, pio_rec_t, dma_acc_t, dma_rec_t, acc_raw;

  always_comb begin
    pio_acc_t = CNT_W'(fields.pio_acc) << 1;
    pio_rec_t = (CNT_W'(fields.pio_rec) << 1) + CNT_W'(PIO_OFS_TICKS)
              + (fields.pio_ext ? CNT_W'(2) : CNT_W'(0));
    if (fields.half) begin
      dma_acc_t = (CNT_W'(fields.dma_acc) << 1) + CNT_W'(1);
      dma_rec_t = (CNT_W'(fields.dma_rec) << 1) + CNT_W'(1);
    end else begin
      dma_acc_t = CNT_W'(fields.dma_acc) << 1;
      dma_rec_t = (CNT_W'(fields.dma_rec) << 1) + CNT_W'(DMA_OFS_TICKS);
    end
    acc_raw   = is_dma ? dma_acc_t : pio_acc_t;
    acc_ticks = (acc_raw == '0) ? CNT_W'(1) : acc_raw;
    rec_ticks = is_dma ? dma_rec_t : pio_rec_t;
  end
endmodule

// File: rtl/ata_tim_prescale.sv
module ata_tim_prescale #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [PW-1:0] div_q;

  assign tick = (div_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (restart || tick) div_q <= '0;
    else                     div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
  import ata_tim_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_is_dma,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  acc_ticks,
  input  logic [CNT_W-1:0]  rec_ticks,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              start,
  output seq_state_t        state,
  output logic              cur_dma,
  output logic              cur_write,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rec_q;
  logic             last_tick;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_ready && req_valid;
  assign last_tick = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      rec_q     <= '0;
      cur_dma   <= 1'b0;
      cur_write <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_ACCESS;
          cnt_q     <= acc_ticks;
          rec_q     <= rec_ticks;
          cur_dma   <= req_is_dma;
          cur_write <= req_write;
          wdata_q   <= req_wdata;
        end
        ST_ACCESS: if (last_tick) begin
          state <= ST_RECOV;
          cnt_q <= rec_q;
          if (!cur_write) rdata_q <= bus_din;
        end else if (tick) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_RECOV: if (last_tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (tick) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_cycle_timer.sv
module ata_cycle_timer
  import ata_tim_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int TICK_DIV      = 1,
  parameter int PIO_OFS_TICKS = 8,
  parameter int DMA_OFS_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [31:0]       cfg_wr_data,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_dma,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_rd_stb,
  output logic              bus_wr_stb,
  output logic              bus_drive_en,
  output logic              bus_is_dma,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int MAX_TICKS = 2 * (2 ** FIELD_W) + PIO_OFS_TICKS + DMA_OFS_TICKS + 4;
  localparam int CNT_W     = $clog2(MAX_TICKS);

  tim_fields_t      fields;
  logic [CNT_W-1:0] acc_ticks, rec_ticks;
  logic             tick, start, cur_dma, cur_write, busy;
  seq_state_t       state;

  ata_tim_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rdata), .fields(fields)
  );

  ata_tim_calc #(.CNT_W(CNT_W), .PIO_OFS_TICKS(PIO_OFS_TICKS), .DMA_OFS_TICKS(DMA_OFS_TICKS)) u_calc (
    .fields(fields), .is_dma(req_is_dma), .acc_ticks(acc_ticks), .rec_ticks(rec_ticks)
  );

  ata_tim_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick)
  );

  ata_tim_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_is_dma(req_is_dma), .req_write(req_write), .req_wdata(req_wdata),
    .acc_ticks(acc_ticks), .rec_ticks(rec_ticks), .bus_din(bus_din),
    .req_ready(req_ready), .start(start), .state(state), .cur_dma(cur_dma),
    .cur_write(cur_write), .wdata_q(bus_dout), .rdata_q(rsp_rdata), .done(rsp_done)
  );

  assign busy         = (state != ST_IDLE);
  assign bus_rd_stb   = (state == ST_ACCESS) && !cur_write;
  assign bus_wr_stb   = (state == ST_ACCESS) &&  cur_write;
  assign bus_drive_en = busy && cur_write;
  assign bus_is_dma   = busy && cur_dma;
endmodule

// File: rtl/ata_cycle_timer_chk.sv
module ata_cycle_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_rdata,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        bus_rd_stb,
  input logic        bus_wr_stb,
  input logic        bus_drive_en,
  input logic        bus_is_dma
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:22] == 10'd0);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_rd_stb && !bus_wr_stb && !bus_drive_en));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_stb && bus_wr_stb));

  p_wr_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_stb |-> bus_drive_en);

  p_rd_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_stb |-> !bus_drive_en);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_recov_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_stb) || $fell(bus_wr_stb)) |-> !req_ready);

  p_kind_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(bus_is_dma));
endmodule

bind ata_cycle_timer ata_cycle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_ready(req_ready),
  .rsp_done(rsp_done), .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
  .bus_drive_en(bus_drive_en), .bus_is_dma(bus_is_dma)
);

// File: tb/sim_ata_cycle_timer.sv
module sim_ata_cycle_timer;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [31:0]   cfg_wr_data = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0, req_ready, req_is_dma = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, bus_dout, bus_din = '0;
  logic          rsp_done, bus_rd_stb, bus_wr_stb, bus_drive_en, bus_is_dma;

  int checks = 0, failures = 0;
  logic [31:0] model_cfg = '0;

  int q_acc[$], q_rec[$], q_wr[$], q_data[$];

  always #5 clk = ~clk;

  ata_cycle_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_dma(req_is_dma), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_rd_stb(bus_rd_stb),
    .bus_wr_stb(bus_wr_stb), .bus_drive_en(bus_drive_en), .bus_is_dma(bus_is_dma),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Expected phase lengths in ticks, from the requirement formulas
  function automatic int exp_acc(input logic [31:0] c, input bit dma);
    int a;
    if (!dma) a = 2 * int'(c[4:0]);
    else a = 2 * int'(c[15:11]) + (c[21] ? 1 : 0);
    return (a == 0) ? 1 : a;
  endfunction

  function automatic int exp_rec(input logic [31:0] c, input bit dma);
    if (!dma) return 2 * int'(c[9:5]) + 8 + (c[10] ? 2 : 0);
    return 2 * int'(c[20:16]) + (c[21] ? 1 : 2);
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_cfg = v;
  endtask

  // Driver: waits for ready, issues one request, pushes the expectation
  task automatic issue(input bit dma, input bit wr, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_dma = dma; req_write = wr;
    if (wr) req_wdata = d; else bus_din = d;
    q_acc.push_back(exp_acc(model_cfg, dma));
    q_rec.push_back(exp_rec(model_cfg, dma));
    q_wr.push_back(int'(wr));
    q_data.push_back(int'(d));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: measures each cycle at the falling edge and compares
  int  m_acc = 0, m_rec = 0, m_bad_bus = 0;
  bit  m_active = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd_stb || bus_wr_stb) begin
        m_active = 1'b1;
        m_acc++;
        if (q_wr.size() > 0) begin
          if (q_wr[0] != 0) begin
            if (!bus_wr_stb || bus_rd_stb || !bus_drive_en || int'(bus_dout) != q_data[0]) m_bad_bus++;
          end else begin
            if (!bus_rd_stb || bus_wr_stb || bus_drive_en) m_bad_bus++;
          end
        end
      end else if (rsp_done) begin
        if (q_acc.size() == 0) begin
          check(1'b0, "R9 done with no pending request", 1, 0);
        end else begin
          int ea, er, ew, ed;
          ea = q_acc.pop_front(); er = q_rec.pop_front();
          ew = q_wr.pop_front();  ed = q_data.pop_front();
          check(m_acc == ea, "R3 R5 R6 access ticks", m_acc, ea);
          check(m_rec == er, "R4 R5 R6 recovery ticks", m_rec, er);
          check(m_bad_bus == 0, "R8 strobe/drive/data during access", m_bad_bus, 0);
          check(req_ready === 1'b1, "R9 ready with done", int'(req_ready), 1);
          if (ew == 0) check(int'(rsp_rdata) == ed, "R7 read data", int'(rsp_rdata), ed);
        end
        m_acc = 0; m_rec = 0; m_bad_bus = 0; m_active = 1'b0;
      end else if (m_active) begin
        m_rec++;
        if (q_wr.size() > 0 && (q_wr[0] != 0) != bus_drive_en) m_bad_bus++;
      end
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      check(1'b0, "watchdog expired", wd, 100000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(!bus_rd_stb && !bus_wr_stb && !bus_drive_en && !rsp_done, "R1 outputs quiet", 1, 0);
    check(cfg_rdata === 32'd0, "R1 cfg zero", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 read-back masking
    cfg_write(32'hFFFF_FFFF);
    check(cfg_rdata === 32'h003F_FFFF, "R2 unused bits zero", int'(cfg_rdata), 32'h003F_FFFF);

    // R3 R4 R7: PIO read, access 6 units, recovery 10 units (600 ns)
    cfg_write({22'd0, 1'b0, 5'd10, 5'd6} | 32'h0);
    issue(1'b0, 1'b0, 16'hA5C3);
    // R4 R8: PIO write with extend bit
    cfg_write({21'd0, 1'b1, 5'd4, 5'd3});
    issue(1'b0, 1'b1, 16'h1234);
    // R3: zero access field gives one tick
    cfg_write(32'd0);
    issue(1'b0, 1'b0, 16'h0F0F);
    // R5: DMA read, access 8 units, recovery 7 units, half-tick clear (480 ns)
    cfg_write((32'd7 << 16) | (32'd8 << 11));
    issue(1'b1, 1'b0, 16'hBEEF);
    // R6: DMA write, half-tick set, access 2, recovery 1 (120 ns)
    cfg_write((32'd1 << 21) | (32'd1 << 16) | (32'd2 << 11));
    issue(1'b1, 1'b1, 16'h7E57);
    // R5: zero DMA access field, half-tick clear
    cfg_write(32'd3 << 16);
    issue(1'b1, 1'b0, 16'h0001);

    // R10: rewrite the timing word mid-cycle; only the next cycle changes
    cfg_write({22'd0, 1'b0, 5'd2, 5'd4});
    issue(1'b0, 1'b0, 16'h5555);
    cfg_write({22'd0, 1'b0, 5'd1, 5'd1});
    check(req_ready === 1'b0, "R10 write landed mid-cycle", int'(req_ready), 0);
    issue(1'b0, 1'b1, 16'hAAAA);

    // drain the scoreboard
    while (q_acc.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!rsp_done && req_ready, "R9 idle after drain", int'(rsp_done), 0);
    summary();
  end
endmodule